// File: doc/BRIEF.md
# Gated Frequency and Integrating Counter

This block measures the frequency of an external, asynchronous signal. It counts the rising edges of that signal during a gate window of known length, so the result is proportional to frequency. A controller loads four settings: a run bit, a two-bit gate-length code, a short-settle bit and a frame line. The settings take effect when the frame line falls. Each measurement starts with a settling interval and then opens the gate. When the gate closes, the block raises a completion flag and holds the count until the controller reads it.

The input is resynchronised to the system clock, and its rising edges are halved before they reach the counter. A gate of G milliseconds therefore yields about f·G/2 counts. Writing the run bit as 0 clears the result. Writing it as 1 again while it is already 1 starts a fresh settle-and-gate sequence. That sequence adds its counts to the held value, which allows readings to be integrated over several gates.

All intervals are whole ticks of one millisecond. The tick is derived from the system clock by a parameterised divider. The divider is restarted on each committed write, so window lengths are exact multiples of the tick.

Top module: `gated_freq_counter`

## Requirements
- R1: After reset, `count_o` is 0 and `done_o` is 0.
- R2: The settings on `start_bit`, `gate_sel` and `fast_wait` act only on the clock where a falling edge of `frame_en` is seen. While `frame_en` stays high, no measurement runs and outputs keep their values.
- R3: The gate length is set by `gate_sel`: code 0 gives 4 ticks, 1 gives 8, 2 gives 32 and 3 gives 64.
- R4: The settle interval before the gate is 3 ticks for gate codes 0 and 1, and 7 ticks for codes 2 and 3, when `fast_wait` is 0. It is 1 tick for any code when `fast_wait` is 1. `done_o` rises (settle + gate) × TICK_DIV clocks after the commit edge.
- R5: During the gate, the count grows by one for every second rising edge of `sig_in`. The result is within ±1 of the number of input rising edges in the gate divided by 2.
- R6: A commit with `start_bit` 0 clears `count_o` and `done_o` on the following clock.
- R7: `done_o` rises when the gate closes. It then stays high, and `count_o` stays constant, until the next commit.
- R8: A commit with `start_bit` 1 does not clear the count. A new settle and gate follow, and the new counts are added to the held value.
- R9: A commit with `start_bit` 1 drops `done_o` on the following clock.
- R10: The count is a CNT_W-bit binary value (20 bits by default). It steps by 0 or +1 per clock outside a clearing commit and wraps from all ones to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Signal to measure, asynchronous to `clk` |
| frame_en | input | 1 | Frame line; a falling edge commits the settings |
| start_bit | input | 1 | 1 starts or restarts a measurement, 0 clears |
| gate_sel | input | 2 | Gate length code (4/8/32/64 ticks) |
| fast_wait | input | 1 | 1 shortens the settle interval to 1 tick |
| count_o | output | CNT_W (20) | Accumulated half-edge count |
| done_o | output | 1 | High once the gate has closed, until the next commit |

## Verification
The hardest behaviour to reach from the ports is wraparound of the 20-bit count. Reaching it would take about a million counted edges. To get there quickly, the bench runs a second copy of the block with a 4-bit count on the same stimulus. It integrates three gates without clearing, so the narrow copy passes its wrap point. At every completion, the narrow count must equal the low bits of the full count exactly. The settle and gate lengths are checked by timing, from the commit edge to the rise of `done_o`, for all four gate codes and both settle options.

// File: rtl/gfc_pkg.sv
package gfc_pkg;

  localparam int MS_W = 7;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_GATE = 2'd2,
    PH_HELD = 2'd3
  } gfc_phase_e;

  function automatic logic [MS_W-1:0] gate_len_ms(input logic [1:0] code);
    logic [MS_W-1:0] len;
    case (code)
      2'd0:    len = MS_W'(4);
      2'd1:    len = MS_W'(8);
      2'd2:    len = MS_W'(32);
      default: len = MS_W'(64);
    endcase
    return len;
  endfunction

  function automatic logic [MS_W-1:0] settle_len_ms(input logic [1:0] code,
                                                    input logic       fast);
    logic [MS_W-1:0] len;
    if (fast)         len = MS_W'(1);
    else if (code[1]) len = MS_W'(7);
    else              len = MS_W'(3);
    return len;
  endfunction

endpackage

// File: rtl/gfc_tick_gen.sv
module gfc_tick_gen #(
  parameter int TICK_DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_q, div_n;

  assign tick_o = (div_q == LAST);

  always_comb begin
    if (restart || tick_o) div_n = '0;
    else                   div_n = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_n;
  end
endmodule

// File: rtl/gfc_edge_div.sv
module gfc_edge_div #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic half_pulse_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              last_q;
  logic              half_q, half_n;
  logic              pulse_q, pulse_n;
  logic              rise;

  generate
    for (genvar s = 0; s < SYNC_N; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= sig_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign rise = sync_q[SYNC_N-1] & ~last_q;

  always_comb begin
    half_n  = half_q;
    pulse_n = 1'b0;
    if (rise) begin
      half_n  = ~half_q;
      pulse_n = half_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= 1'b0;
      half_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      last_q  <= sync_q[SYNC_N-1];
      half_q  <= half_n;
      pulse_q <= pulse_n;
    end
  end

  assign half_pulse_o = pulse_q;
endmodule

// File: rtl/gfc_ctrl.sv
module gfc_ctrl
  import gfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit,
  input  logic       start_bit,
  input  logic [1:0] gate_sel,
  input  logic       fast_wait,
  input  logic       tick,
  output logic       count_en,
  output logic       count_clr,
  output logic       done_o
);
  gfc_phase_e      phase_q, phase_n;
  logic [MS_W-1:0] ms_q, ms_n;
  logic [1:0]      gate_q, gate_n;
  logic            fast_q, fast_n;
  logic            done_q, done_n;
  logic [MS_W-1:0] limit;

  always_comb begin
    if (phase_q == PH_WAIT) limit = settle_len_ms(gate_q, fast_q);
    else                    limit = gate_len_ms(gate_q);
  end

  always_comb begin
    phase_n = phase_q;
    ms_n    = ms_q;
    gate_n  = gate_q;
    fast_n  = fast_q;
    done_n  = done_q;
    if (commit) begin
      gate_n  = gate_sel;
      fast_n  = fast_wait;
      done_n  = 1'b0;
      ms_n    = '0;
      phase_n = start_bit ? PH_WAIT : PH_IDLE;
    end else if (tick && (phase_q == PH_WAIT || phase_q == PH_GATE)) begin
      if (ms_q == limit - 1'b1) begin
        ms_n = '0;
        if (phase_q == PH_WAIT) begin
          phase_n = PH_GATE;
        end else begin
          phase_n = PH_HELD;
          done_n  = 1'b1;
        end
      end else begin
        ms_n = ms_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ms_q    <= '0;
      gate_q  <= 2'd0;
      fast_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      ms_q    <= ms_n;
      gate_q  <= gate_n;
      fast_q  <= fast_n;
      done_q  <= done_n;
    end
  end

  assign count_en  = (phase_q == PH_GATE);
  assign count_clr = commit & ~start_bit;
  assign done_o    = done_q;
endmodule

// File: rtl/gfc_accum.sv
module gfc_accum #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             pulse,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_ce;

  assign cnt_ce = clr | (en & pulse);

  always_comb begin
    if (clr) cnt_n = '0;
    else     cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_n;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/gated_freq_counter.sv
module gated_freq_counter #(
  parameter int CNT_W    = 20,
  parameter int TICK_DIV = 50000,
  parameter int SYNC_N   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic             frame_en,
  input  logic             start_bit,
  input  logic [1:0]       gate_sel,
  input  logic             fast_wait,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);
  logic frame_q;
  logic commit;
  logic tick;
  logic half_pulse;
  logic count_en;
  logic count_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= 1'b0;
    else        frame_q <= frame_en;
  end

  assign commit = frame_q & ~frame_en;

  gfc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (commit),
    .tick_o  (tick)
  );

  gfc_edge_div #(.SYNC_N(SYNC_N)) u_edge (
    .clk          (clk),
    .rst_n        (rst_n),
    .sig_in       (sig_in),
    .half_pulse_o (half_pulse)
  );

  gfc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .start_bit (start_bit),
    .gate_sel  (gate_sel),
    .fast_wait (fast_wait),
    .tick      (tick),
    .count_en  (count_en),
    .count_clr (count_clr),
    .done_o    (done_o)
  );

  gfc_accum #(.CNT_W(CNT_W)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (count_clr),
    .en      (count_en),
    .pulse   (half_pulse),
    .count_o (count_o)
  );
endmodule

// File: rtl/gfc_checker.sv
module gfc_checker #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_en,
  input logic             start_bit,
  input logic [CNT_W-1:0] count_o,
  input logic             done_o
);
  logic fe_seen;
  logic wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fe_seen <= 1'b0;
    else        fe_seen <= frame_en;
  end

  assign wr = fe_seen & ~frame_en;

  // R1: reset values
  always_comb begin
    if (!rst_n) begin
      assert_reset_vals_R1: assert (count_o == '0 && !done_o);
    end
  end

  // R6: clearing write
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !start_bit) |=> (count_o == '0 && !done_o));

  // R9: a start write lowers the flag
  assert_done_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && start_bit) |=> !done_o);

  // R7: the flag holds without a write
  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !wr) |=> done_o);

  // R7: the result holds while the flag is high
  assert_count_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !wr) |=> $stable(count_o));

  // R8: a restart keeps the held value
  assert_restart_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && start_bit) |=> (count_o == $past(count_o) ||
                           count_o == CNT_W'($past(count_o) + 1'b1)));

  // R10: unit steps with modular wrap
  assert_wrap_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && !start_bit) |=> (count_o == $past(count_o) ||
                             count_o == CNT_W'($past(count_o) + 1'b1)));

  // R2: nothing finishes while the frame line stays high
  assert_no_change_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_en && fe_seen && !done_o) |=> !$rose(done_o) || !frame_en);
endmodule

bind gated_freq_counter gfc_checker #(.CNT_W(CNT_W)) u_gfc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_en  (frame_en),
  .start_bit (start_bit),
  .count_o   (count_o),
  .done_o    (done_o)
);

// File: tb/gated_freq_counter_bench.sv
module gated_freq_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 40;
  localparam int CW         = 20;
  localparam int SW         = 4;

  typedef struct {
    int    exp_cnt;
    int    tol;
    int    exp_cyc;
    string tag;
  } sb_item_t;

  logic          clk;
  logic          rst_n;
  logic          sig_in;
  logic          frame_en;
  logic          start_bit;
  logic [1:0]    gate_sel;
  logic          fast_wait;
  logic [CW-1:0] count_o;
  logic          done_o;
  logic [SW-1:0] small_cnt;
  logic          small_done;

  sb_item_t sb_q[$];
  int       n_checks;
  int       n_fail;
  time      t_commit;
  logic     done_prev;

  gated_freq_counter #(.CNT_W(CW), .TICK_DIV(TICK)) u_gated_freq_counter (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .frame_en(frame_en),
    .start_bit(start_bit), .gate_sel(gate_sel), .fast_wait(fast_wait),
    .count_o(count_o), .done_o(done_o)
  );

  gated_freq_counter #(.CNT_W(SW), .TICK_DIV(TICK)) u_narrow (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .frame_en(frame_en),
    .start_bit(start_bit), .gate_sel(gate_sel), .fast_wait(fast_wait),
    .count_o(small_cnt), .done_o(small_done)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // input at 8 clock periods per cycle, phase offset from the clock
  initial begin
    sig_in = 1'b0;
    #7;
    forever #(4*CLK_PERIOD) sig_in = ~sig_in;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  // expected lengths from the requirements, in ticks
  function automatic int gate_ticks(input logic [1:0] c);
    return (c == 2'd0) ? 4 : (c == 2'd1) ? 8 : (c == 2'd2) ? 32 : 64;
  endfunction

  function automatic int settle_ticks(input logic [1:0] c, input logic f);
    return f ? 1 : (c[1] ? 7 : 3);
  endfunction

  task automatic write_cfg(input logic st, input logic [1:0] g, input logic f, input int hold);
    @(negedge clk);
    frame_en  = 1'b1;
    start_bit = st;
    gate_sel  = g;
    fast_wait = f;
    repeat (hold) @(negedge clk);
    frame_en = 1'b0;
    t_commit = $time + CLK_PERIOD/2;
  endtask

  task automatic measure(input logic [1:0] g, input logic f, input int exp_cnt,
                         input int tol, input string tag);
    sb_item_t it;
    it.exp_cnt = exp_cnt;
    it.tol     = tol;
    it.exp_cyc = (settle_ticks(g, f) + gate_ticks(g)) * TICK;
    it.tag     = tag;
    sb_q.push_back(it);
    write_cfg(1'b1, g, f, 2);
    @(negedge clk);
    check(done_o == 1'b0, "R9 flag low after start write", int'(done_o), 0);
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic clear_cnt();
    write_cfg(1'b0, 2'd0, 1'b0, 2);
    @(negedge clk);
    check(count_o == '0, "R6 count cleared", int'(count_o), 0);
    check(done_o == 1'b0, "R6 flag cleared", int'(done_o), 0);
  endtask

  // monitor: compares each completion against the scoreboard
  initial begin
    done_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && done_o && !done_prev) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R7 unexpected completion", 1, 0);
        end else begin
          sb_item_t it;
          int cyc;
          int diff;
          it   = sb_q.pop_front();
          cyc  = int'(($time - t_commit) / CLK_PERIOD);
          diff = int'(count_o) - it.exp_cnt;
          check(diff <= it.tol && diff >= -it.tol,
                {it.tag, " R5 count"}, int'(count_o), it.exp_cnt);
          check(cyc >= it.exp_cyc - 2 && cyc <= it.exp_cyc + 2,
                {it.tag, " R3 R4 completion time"}, cyc, it.exp_cyc);
          check(small_cnt == count_o[SW-1:0], "R10 narrow copy wraps",
                int'(small_cnt), int'(count_o[SW-1:0]));
        end
      end
      done_prev = done_o;
    end
  end

  initial begin
    #(200000 * CLK_PERIOD);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [CW-1:0] held;
    n_checks  = 0;
    n_fail    = 0;
    t_commit  = 0;
    rst_n     = 1'b0;
    frame_en  = 1'b0;
    start_bit = 1'b0;
    gate_sel  = 2'd0;
    fast_wait = 1'b0;
    repeat (3) @(negedge clk);
    check(count_o == '0, "R1 reset count", int'(count_o), 0);
    check(done_o == 1'b0, "R1 reset flag", int'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: settings staged with frame high for a long time do nothing yet
    begin
      sb_item_t it;
      it.exp_cnt = 10; it.tol = 1; it.exp_cyc = 7 * TICK; it.tag = "R2 gate 4 settle 3";
      sb_q.push_back(it);
      @(negedge clk);
      frame_en = 1'b1; start_bit = 1'b1; gate_sel = 2'd0; fast_wait = 1'b0;
      repeat (400) @(negedge clk);
      check(done_o == 1'b0, "R2 no completion while frame high", int'(done_o), 0);
      check(count_o == '0, "R2 no counting while frame high", int'(count_o), 0);
      frame_en = 1'b0;
      t_commit = $time + CLK_PERIOD/2;
      while (sb_q.size() != 0) @(negedge clk);
    end

    // R7: result and flag hold after the gate closes
    held = count_o;
    repeat (60) @(negedge clk);
    check(done_o == 1'b1, "R7 flag stays high", int'(done_o), 1);
    check(count_o == held, "R7 count held", int'(count_o), int'(held));

    clear_cnt();
    measure(2'd1, 1'b0, 20, 1, "R3 gate 8 settle 3");
    clear_cnt();
    measure(2'd2, 1'b0, 80, 1, "R3 gate 32 settle 7");
    clear_cnt();
    measure(2'd3, 1'b1, 160, 1, "R4 gate 64 short settle");
    clear_cnt();

    // R8 and R10: integrate three short gates without clearing
    measure(2'd0, 1'b1, 10, 1, "R8 first gate");
    measure(2'd0, 1'b1, 20, 2, "R8 second gate adds");
    measure(2'd0, 1'b1, 30, 3, "R8 third gate adds");
    check(count_o > 20'd16, "R10 total beyond narrow range", int'(count_o), 17);

    clear_cnt();
    finish_run();
  end
endmodule